// File: doc/BRIEF.md
# Mailbox Unread-Overwrite Status Tracker

This block keeps one sticky flag for each of 16 message mailboxes. A flag records that a new frame arrived in its mailbox while the previous frame was still waiting for the CPU. A mailbox counts as still waiting when its receive-pending flag or its remote-frame-pending flag is set. The receive engine gives the block a per-mailbox receive strobe. The mailbox configuration gives a per-mailbox transmit/receive direction. The block takes both pending-flag vectors as they stand in the cycle of the event, before that event updates them.

The CPU reads the 16 flags as one status word. Bit n belongs to mailbox n. Reading has no side effects. To acknowledge flags, the CPU makes a single-cycle write whose data bus holds a 1 in each bit it wants to clear. When a hardware set and a CPU clear land on the same bit in the same cycle, the set wins, so an overwrite is never lost.

Top module: `ovw_tracker`

## Requirements
- R1: While the active-low reset is asserted, and on the first cycle after it is released, every bit of `statusQ` is 0.
- R2: A receive strobe on `rxHit[n]` for a receive mailbox (`mbIsTx[n]`=0) while `rxPending[n]`=1 sets `statusQ[n]` at the next clock edge.
- R3: A receive strobe on `rxHit[n]` for a receive mailbox while `remPending[n]`=1 sets `statusQ[n]` at the next clock edge.
- R4: A receive strobe on a mailbox whose own two pending flags are both 0 leaves its status bit unchanged. Pending flags of other mailboxes have no influence on it.
- R5: A mailbox with `mbIsTx[n]`=1 never has its status bit set, whatever its strobe and pending flags.
- R6: A cycle with `regWrEn`=1 clears every status bit whose `regWrData` bit is 1, at the next clock edge.
- R7: A write with a data bit of 0 leaves the matching status bit unchanged.
- R8: When a qualifying set and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R9: A set status bit stays 1 across later overwrites of the same mailbox and across events on other mailboxes, until it is cleared.
- R10: With no strobe and no write, `statusQ` holds its value. It is a plain register output, so reading it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxHit | input | 16 | Per-mailbox new-frame strobe, at most one bit per cycle |
| mbIsTx | input | 16 | Per-mailbox direction, 1 = transmit |
| rxPending | input | 16 | Receive-pending flags, pre-event value |
| remPending | input | 16 | Remote-frame-pending flags, pre-event value |
| regWrEn | input | 1 | Single-cycle status write strobe |
| regWrData | input | 16 | Write data, 1 = clear that bit |
| statusQ | output | 16 | Sticky overwrite status, bit n = mailbox n |

## Verification
The checker tests several rules on every clock. Each qualifying event must appear in the status word one edge later. Every new 1 must trace back to such an event, which covers transmit mailboxes and first receptions. A written 1 must clear its bit unless a set hit that bit in the same cycle. A bit at 1 that nobody cleared must stay at 1. The bench scenarios cover the rest: the reset value, the exact word after a chain of mixed events, and the case where a clear and a transmit-mailbox strobe share a cycle, which shows that the set can only win when it qualifies.

// File: rtl/ovw_pkg.sv
package ovw_pkg;
  localparam int NUM_MB = 16;

  typedef struct packed {
    logic [NUM_MB-1:0] setStb;
    logic [NUM_MB-1:0] clrStb;
  } ovwStrobes_t;
endpackage

// File: rtl/ovw_ctrl.sv
module ovw_ctrl
  import ovw_pkg::*;
#(
  parameter int numMb = NUM_MB
) (
  input  logic [numMb-1:0] rxHit,
  input  logic [numMb-1:0] mbIsTx,
  input  logic [numMb-1:0] rxPending,
  input  logic [numMb-1:0] remPending,
  input  logic             regWrEn,
  input  logic [numMb-1:0] regWrData,
  output ovwStrobes_t      strobes
);
  logic [numMb-1:0] setVec;
  logic [numMb-1:0] clrVec;

  // One qualifier per mailbox. The pending flags are the values from before this event.
  for (genvar gi = 0; gi < numMb; gi++) begin : g_qual
    logic stillUnread;
    assign stillUnread = rxPending[gi] | remPending[gi];
    assign setVec[gi]  = rxHit[gi] & ~mbIsTx[gi] & stillUnread;
    assign clrVec[gi]  = regWrEn & regWrData[gi];
  end

  always_comb begin
    strobes        = '0;
    strobes.setStb = setVec;
    strobes.clrStb = clrVec;
  end
endmodule

// File: rtl/ovw_status.sv
module ovw_status
  import ovw_pkg::*;
#(
  parameter int numMb = NUM_MB
) (
  input  logic             clk,
  input  logic             rstN,
  input  ovwStrobes_t      strobes,
  output logic [numMb-1:0] statusQ
);
  for (genvar gi = 0; gi < numMb; gi++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     statusQ[gi] <= 1'b0;
      else if (strobes.setStb[gi])   statusQ[gi] <= 1'b1;  // a set beats a clear
      else if (strobes.clrStb[gi])   statusQ[gi] <= 1'b0;
    end
  end
endmodule

// File: rtl/ovw_tracker.sv
module ovw_tracker
  import ovw_pkg::*;
#(
  parameter int numMb = NUM_MB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [numMb-1:0] rxHit,
  input  logic [numMb-1:0] mbIsTx,
  input  logic [numMb-1:0] rxPending,
  input  logic [numMb-1:0] remPending,
  input  logic             regWrEn,
  input  logic [numMb-1:0] regWrData,
  output logic [numMb-1:0] statusQ
);
  ovwStrobes_t strobes;

  ovw_ctrl #(.numMb(numMb)) ctrl_i (
    .rxHit(rxHit), .mbIsTx(mbIsTx), .rxPending(rxPending),
    .remPending(remPending), .regWrEn(regWrEn), .regWrData(regWrData),
    .strobes(strobes)
  );

  ovw_status #(.numMb(numMb)) status_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusQ(statusQ)
  );
endmodule

// File: rtl/ovw_tracker_chk.sv
module ovw_tracker_chk #(
  parameter int numMb = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [numMb-1:0] rxHit,
  input logic [numMb-1:0] mbIsTx,
  input logic [numMb-1:0] rxPending,
  input logic [numMb-1:0] remPending,
  input logic             regWrEn,
  input logic [numMb-1:0] regWrData,
  input logic [numMb-1:0] statusQ
);
  logic [numMb-1:0] qualEv;
  logic [numMb-1:0] wrOnes;
  assign qualEv = rxHit & ~mbIsTx & (rxPending | remPending);
  assign wrOnes = regWrEn ? regWrData : '0;

  // R2 R3 R8
  qual_event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & $past(qualEv)) == $past(qualEv)));

  // R4 R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(qualEv)) == '0));

  // R6
  write_one_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & $past(wrOnes) & ~$past(qualEv)) == '0));

  // R7 R9 R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~$past(wrOnes) & ~statusQ) == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (!rstN |=> (statusQ == '0)));
endmodule

bind ovw_tracker ovw_tracker_chk #(.numMb(numMb)) chk_i (
  .clk(clk), .rstN(rstN), .rxHit(rxHit), .mbIsTx(mbIsTx),
  .rxPending(rxPending), .remPending(remPending), .regWrEn(regWrEn),
  .regWrData(regWrData), .statusQ(statusQ)
);

// File: tb/ovw_tracker_tb_top.sv
`timescale 1ns/1ps
module ovw_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] rxHit = '0, mbIsTx = '0, rxPending = '0, remPending = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] statusQ;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ovw_tracker dut_i (
    .clk(clk), .rstN(rstN), .rxHit(rxHit), .mbIsTx(mbIsTx),
    .rxPending(rxPending), .remPending(remPending), .regWrEn(regWrEn),
    .regWrData(regWrData), .statusQ(statusQ)
  );

  typedef struct packed {
    logic [15:0] hit, tx, rxp, remp;
    logic        we;
    logic [15:0] wd, exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 8'd4},  // R4 first reception
    '{16'h0001, 16'h0000, 16'h0001, 16'h0000, 1'b0, 16'h0000, 16'h0001, 8'd2},  // R2
    '{16'h0020, 16'h0000, 16'h0000, 16'h0020, 1'b0, 16'h0000, 16'h0021, 8'd3},  // R3
    '{16'h0100, 16'h0100, 16'h0100, 16'h0000, 1'b0, 16'h0000, 16'h0021, 8'd5},  // R5
    '{16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 16'h8021, 8'd2},  // R2 top bit
    '{16'h0001, 16'h0000, 16'h0001, 16'h0000, 1'b0, 16'h0000, 16'h8021, 8'd9},  // R9
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h0000, 16'h8021, 8'd7},  // R7
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h0020, 16'h8001, 8'd6},  // R6
    '{16'h8000, 16'h0000, 16'h0000, 16'h8000, 1'b1, 16'h8000, 16'h8001, 8'd8},  // R8
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'hFFFF, 16'h0000, 8'd6},  // R6 all
    '{16'h0004, 16'h0000, 16'h0008, 16'h0000, 1'b0, 16'h0000, 16'h0000, 8'd4},  // R4 other pending
    '{16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 8'd10}, // R10
    '{16'h0400, 16'hFBFF, 16'h0400, 16'h0000, 1'b0, 16'h0000, 16'h0400, 8'd2},  // R2 among tx boxes
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0400, 8'd10}, // R10 hold
    '{16'h0400, 16'h0400, 16'h0400, 16'h0000, 1'b1, 16'h0400, 16'h0000, 8'd5}   // R5 tx cannot beat clear
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: statusQ=%h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rxHit = '0; mbIsTx = '0; rxPending = '0; remPending = '0;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: held in reset
    repeat (3) @(negedge clk);
    check(statusQ, 16'h0000, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(statusQ, 16'h0000, 1);

    for (int k = 0; k < NV; k++) begin
      rxHit = VECS[k].hit; mbIsTx = VECS[k].tx;
      rxPending = VECS[k].rxp; remPending = VECS[k].remp;
      regWrEn = VECS[k].we; regWrData = VECS[k].wd;
      @(negedge clk);
      check(statusQ, VECS[k].exp, int'(VECS[k].req));
    end
    idle();

    // R9: bits on several mailboxes stay set through more events
    rxHit = 16'h0002; rxPending = 16'h0002; @(negedge clk);
    rxHit = 16'h4000; remPending = 16'h4000; rxPending = '0; @(negedge clk);
    rxHit = 16'h0002; rxPending = 16'h0002; remPending = '0; @(negedge clk);
    idle(); @(negedge clk);
    check(statusQ, 16'h4002, 9);

    // R1: reset in the middle of a run clears everything
    rstN = 1'b0; @(negedge clk);
    check(statusQ, 16'h0000, 1);
    rstN = 1'b1; @(negedge clk);
    check(statusQ, 16'h0000, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule